// File: doc/BRIEF.md
# Prioritized Interrupt Acceptance Controller

This block owns the 16-bit processor status word and decides, cycle by cycle, whether any of its N pending interrupt requests may be taken. Each request carries a 4-bit priority level and a flag that asks for a single-cycle peripheral transfer instead of a full service-routine entry. A request is eligible only while the global enable bit of the status word is set and its level is strictly above the CPU level held in that word. Among eligible requests the highest level wins, and on equal levels the lowest index wins.

A winning transfer request (level 14 or 15 with its flag set) is acknowledged in the same cycle it is decided. It does not touch the status word and nothing goes to the stack. Any other winner starts a service entry. First the current status word is offered to the stack on a push handshake. When the stack takes it, the request is acknowledged and the CPU level field is loaded with the winner's level. Software can rewrite the status word directly. A return strobe reloads it from the word popped off the stack. The hold-enable bit is brought out for the bus arbitration logic.

Top module: `irq_accept_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, the status word is 0000h, and `ack_vld` and `push_vld` are low.
- R2: A request is acknowledged only if its level is strictly greater than the CPU level in status bits 15:12. Requests at an equal or lower level get no acknowledge.
- R3: While status bit 11 (global enable) is 0, no request is acknowledged.
- R4: The eligible request with the highest level wins. Among equal levels the lowest index wins. The winner's index appears on `ack_idx`.
- R5: A service entry drives `push_vld` high from the cycle after the decision, with `push_data` equal to the status word. `push_vld` and `push_data` hold until `push_rdy`. In the cycle `push_rdy` is high, `ack_vld` is 1 and `ack_xfer` is 0. After that edge, bits 15:12 of the status word equal the winner's level, and every other bit is unchanged.
- R6: A winner at level 14 or 15 with its transfer flag set is acknowledged combinationally in the decision cycle, with `ack_xfer` = 1. No push follows, and the status word is unchanged.
- R7: A winner at levels 1 to 13 always gets a service entry (`ack_xfer` = 0 after a push), even when its transfer flag is set.
- R8: A software write (`psw_we`) loads `psw_wdata` into the status word at the clock edge, with bits 9:7 forced to 0. Acceptance decisions use the new value from the next cycle onward. `hold_en` equals status bit 10.
- R9: `ret_stb` loads `pop_data` into the status word at the clock edge, with bits 9:7 forced to 0.
- R10: When no entry is in progress, `psw_we` takes precedence over `ret_stb`. A cycle with either strobe starts no service entry, but it can still grant a transfer, and that grant is judged on the old status word. While an entry waits for `push_rdy`, both strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_vld | input | N_REQ | Request pending, one bit per source |
| req_lvl | input | 4*N_REQ | Request levels, source i in bits 4i+3:4i |
| req_xfer | input | N_REQ | Request asks for a single-cycle transfer |
| psw_we | input | 1 | Software write strobe for the status word |
| psw_wdata | input | 16 | Software write data |
| ret_stb | input | 1 | Return-from-interrupt strobe |
| pop_data | input | 16 | Status word popped from the stack, valid with `ret_stb` |
| push_rdy | input | 1 | Stack accepts the pushed word this cycle |
| ack_vld | output | 1 | Request acknowledged this cycle |
| ack_idx | output | IDX_W | Index of the acknowledged request |
| ack_xfer | output | 1 | Acknowledge is a single-cycle transfer |
| push_vld | output | 1 | Status word offered to the stack |
| push_data | output | 16 | Status word being saved |
| psw | output | 16 | Current status word |
| hold_en | output | 1 | Hold-enable bit of the status word |

## Verification
A transfer grant and a software write of the status word can fall in the same cycle. The bench provokes this by writing a level of Fh while a level-15 transfer request is pending. The grant must still appear in that cycle, judged on the old level, and the same request must be refused in the next cycle. A second collision comes from raising a service request together with a write. No push may follow that cycle, the entry must start one cycle later, and write and return strobes given while the push waits must leave the word untouched.

// File: rtl/irq_pkg.sv
package irq_pkg;

  localparam int PSW_W        = 16;
  localparam int LVL_W        = 4;
  localparam int LVL_LSB      = 12;
  localparam int IEN_BIT      = 11;
  localparam int HOLD_BIT     = 10;
  localparam int XFER_MIN_LVL = 14;

  localparam logic [PSW_W-1:0] PSW_SPARE_MASK = 16'h0380;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_PUSH = 1'b1
  } entry_st_e;

  function automatic logic [PSW_W-1:0] psw_clean(input logic [PSW_W-1:0] v);
    return v & ~PSW_SPARE_MASK;
  endfunction

endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int N_REQ = 4,
  parameter int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_REQ-1:0]   req_vld,
  input  logic [N_REQ*LVL_W-1:0] req_lvl,
  input  logic [N_REQ-1:0]   req_xfer,
  input  logic [LVL_W-1:0]   cpu_lvl,
  input  logic               ien,
  output logic               win_any,
  output logic [IDX_W-1:0]   win_idx,
  output logic [LVL_W-1:0]   win_lvl,
  output logic               win_xfer
);

  logic [LVL_W-1:0] lvl_a [N_REQ];
  logic [N_REQ-1:0] elig;
  logic             best_flag;

  for (genvar g = 0; g < N_REQ; g++) begin : g_elig
    assign lvl_a[g] = req_lvl[g*LVL_W +: LVL_W];
    assign elig[g]  = ien & req_vld[g] & (lvl_a[g] > cpu_lvl);
  end

  // Linear scan: a later source only replaces the best on a strictly
  // higher level, so equal levels keep the lower index.
  always_comb begin
    win_any   = 1'b0;
    win_idx   = '0;
    win_lvl   = '0;
    best_flag = 1'b0;
    for (int i = 0; i < N_REQ; i++) begin
      if (elig[i] && (!win_any || (lvl_a[i] > win_lvl))) begin
        win_any   = 1'b1;
        win_idx   = IDX_W'(i);
        win_lvl   = lvl_a[i];
        best_flag = req_xfer[i];
      end
    end
  end

  assign win_xfer = win_any & best_flag & (win_lvl >= LVL_W'(XFER_MIN_LVL));

  for (genvar g = 0; g < N_REQ; g++) begin : g_chk
    // R4: no eligible source outranks the winner
    a_r4_winner_max: assert property (@(posedge clk) disable iff (!rst_n)
      elig[g] |-> (win_any && (win_lvl >= lvl_a[g])));
    // R4: ties go to the lowest index
    a_r4_tie_low: assert property (@(posedge clk) disable iff (!rst_n)
      (elig[g] && (lvl_a[g] == win_lvl)) |-> (int'(win_idx) <= g));
  end

endmodule

// File: rtl/irq_psw_reg.sv
module irq_psw_reg
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_sw,
  input  logic [PSW_W-1:0] sw_data,
  input  logic             ld_pop,
  input  logic [PSW_W-1:0] pop_data,
  input  logic             ld_lvl,
  input  logic [LVL_W-1:0] new_lvl,
  output logic [PSW_W-1:0] psw_q
);

  logic [PSW_W-1:0] psw_d;
  logic             psw_en;

  assign psw_en = ld_sw | ld_pop | ld_lvl;

  always_comb begin
    psw_d = psw_q;
    if (ld_sw) begin
      psw_d = psw_clean(sw_data);
    end else if (ld_pop) begin
      psw_d = psw_clean(pop_data);
    end else if (ld_lvl) begin
      psw_d[LVL_LSB +: LVL_W] = new_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psw_q <= '0;
    end else if (psw_en) begin
      psw_q <= psw_d;
    end
  end

  // R8: spare bits never hold a one
  a_r8_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (psw_q & PSW_SPARE_MASK) == '0);

  // R5: a level load touches only the level field
  a_r5_lvl_only: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_lvl && !ld_sw && !ld_pop) |=>
      (psw_q[LVL_LSB-1:0] == $past(psw_q[LVL_LSB-1:0])));

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_pkg::*;
#(
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             svc_start,
  input  logic [IDX_W-1:0] win_idx,
  input  logic [LVL_W-1:0] win_lvl,
  input  logic             push_rdy,
  output logic             busy,
  output logic             push_vld,
  output logic             done,
  output logic [IDX_W-1:0] held_idx,
  output logic [LVL_W-1:0] held_lvl
);

  entry_st_e        st_q, st_d;
  logic             hold_en_w;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (svc_start) st_d = ST_PUSH;
      ST_PUSH: if (push_rdy)  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  assign hold_en_w = (st_q == ST_IDLE) & svc_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_idx <= '0;
      held_lvl <= '0;
    end else if (hold_en_w) begin
      held_idx <= win_idx;
      held_lvl <= win_lvl;
    end
  end

  assign busy     = (st_q == ST_PUSH);
  assign push_vld = busy;
  assign done     = busy & push_rdy;

  // R5: the latched winner stays fixed while the push waits
  a_r5_held_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !push_rdy) |=> (busy && $stable(held_idx) && $stable(held_lvl)));

endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl
  import irq_pkg::*;
#(
  parameter int N_REQ = 4,
  parameter int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_REQ-1:0]       req_vld,
  input  logic [N_REQ*LVL_W-1:0] req_lvl,
  input  logic [N_REQ-1:0]       req_xfer,
  input  logic                   psw_we,
  input  logic [PSW_W-1:0]       psw_wdata,
  input  logic                   ret_stb,
  input  logic [PSW_W-1:0]       pop_data,
  input  logic                   push_rdy,
  output logic                   ack_vld,
  output logic [IDX_W-1:0]       ack_idx,
  output logic                   ack_xfer,
  output logic                   push_vld,
  output logic [PSW_W-1:0]       push_data,
  output logic [PSW_W-1:0]       psw,
  output logic                   hold_en
);

  logic [1:0]       rst_sync_q;
  logic             rst_i_n;
  logic [PSW_W-1:0] psw_q;
  logic             win_any, win_xfer;
  logic [IDX_W-1:0] win_idx, held_idx;
  logic [LVL_W-1:0] win_lvl, held_lvl;
  logic             busy, done, idle;
  logic             xfer_go, svc_start;
  logic             ld_sw, ld_pop;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_i_n = rst_sync_q[1];

  irq_arbiter #(.N_REQ(N_REQ), .IDX_W(IDX_W)) u_arb (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .req_vld  (req_vld),
    .req_lvl  (req_lvl),
    .req_xfer (req_xfer),
    .cpu_lvl  (psw_q[LVL_LSB +: LVL_W]),
    .ien      (psw_q[IEN_BIT]),
    .win_any  (win_any),
    .win_idx  (win_idx),
    .win_lvl  (win_lvl),
    .win_xfer (win_xfer)
  );

  assign idle      = ~busy;
  assign xfer_go   = idle & win_any & win_xfer;
  assign svc_start = idle & win_any & ~win_xfer & ~psw_we & ~ret_stb;
  assign ld_sw     = idle & psw_we;
  assign ld_pop    = idle & ret_stb & ~psw_we;

  irq_entry_seq #(.IDX_W(IDX_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .svc_start (svc_start),
    .win_idx   (win_idx),
    .win_lvl   (win_lvl),
    .push_rdy  (push_rdy),
    .busy      (busy),
    .push_vld  (push_vld),
    .done      (done),
    .held_idx  (held_idx),
    .held_lvl  (held_lvl)
  );

  irq_psw_reg u_psw (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .ld_sw    (ld_sw),
    .sw_data  (psw_wdata),
    .ld_pop   (ld_pop),
    .pop_data (pop_data),
    .ld_lvl   (done),
    .new_lvl  (held_lvl),
    .psw_q    (psw_q)
  );

  assign ack_vld   = xfer_go | done;
  assign ack_idx   = done ? held_idx : win_idx;
  assign ack_xfer  = xfer_go;
  assign push_data = psw_q;
  assign psw       = psw_q;
  assign hold_en   = psw_q[HOLD_BIT];

  // R2: an immediate grant is for a level above the CPU level
  a_r2_above_level: assert property (@(posedge clk) disable iff (!rst_i_n)
    ack_xfer |-> (req_lvl[int'(ack_idx)*LVL_W +: LVL_W] > psw_q[LVL_LSB +: LVL_W]));

  // R3: global enable off blocks every acknowledge
  a_r3_enable_gate: assert property (@(posedge clk) disable iff (!rst_i_n)
    !psw_q[IEN_BIT] |-> !ack_vld);

  // R5: pushed word and offer hold until the stack takes it
  a_r5_push_hold: assert property (@(posedge clk) disable iff (!rst_i_n)
    (push_vld && !push_rdy) |=> (push_vld && $stable(push_data)));

  // R5: level field follows the served request after the push
  a_r5_level_load: assert property (@(posedge clk) disable iff (!rst_i_n)
    (ack_vld && !ack_xfer) |=> (psw_q[LVL_LSB +: LVL_W] == $past(held_lvl)));

  // R6: a transfer grant leaves the status word alone
  a_r6_xfer_keeps_psw: assert property (@(posedge clk) disable iff (!rst_i_n)
    (ack_xfer && !psw_we && !ret_stb) |=> $stable(psw_q));

  // R7: only the two top levels may be granted as transfers
  a_r7_xfer_top_only: assert property (@(posedge clk) disable iff (!rst_i_n)
    ack_xfer |-> (req_lvl[int'(ack_idx)*LVL_W +: LVL_W] >= LVL_W'(XFER_MIN_LVL)));

  // R9: a lone return strobe restores the popped word
  a_r9_return_load: assert property (@(posedge clk) disable iff (!rst_i_n)
    (ret_stb && !psw_we && !push_vld) |=>
      (psw_q == ($past(pop_data) & ~PSW_SPARE_MASK)));

  // R10: strobes are ignored while the push waits
  a_r10_busy_ignores: assert property (@(posedge clk) disable iff (!rst_i_n)
    (push_vld && !push_rdy) |=> $stable(psw_q));

  // R10: a strobe cycle starts no entry
  a_r10_no_start: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!push_vld && (psw_we || ret_stb)) |=> !push_vld);

endmodule

// File: tb/tb_irq_accept_ctrl.sv
module tb_irq_accept_ctrl;

  localparam int N  = 4;
  localparam int IW = 2;

  typedef struct packed {
    logic [15:0] psw;
    logic [3:0]  vld;
    logic [15:0] lvl;
    logic [3:0]  xf;
    logic [1:0]  kind;   // 0 none, 1 service, 2 transfer
    logic [1:0]  idx;
    logic [3:0]  wl;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{16'h0800, 4'b0001, 16'h0005, 4'b0000, 2'd1, 2'd0, 4'd5},   // R5
    '{16'h3800, 4'b0011, 16'h0023, 4'b0000, 2'd0, 2'd0, 4'd0},   // R2
    '{16'h3800, 4'b1111, 16'h2994, 4'b0000, 2'd1, 2'd1, 4'd9},   // R4
    '{16'h3000, 4'b0001, 16'h000F, 4'b0001, 2'd0, 2'd0, 4'd0},   // R3
    '{16'h0800, 4'b0100, 16'h0E00, 4'b0100, 2'd2, 2'd2, 4'd14},  // R6
    '{16'h0800, 4'b1000, 16'hD000, 4'b1000, 2'd1, 2'd3, 4'd13},  // R7
    '{16'hE800, 4'b0010, 16'h00F0, 4'b0010, 2'd2, 2'd1, 4'd15},  // R6
    '{16'hF800, 4'b1111, 16'hFFFF, 4'b0000, 2'd0, 2'd0, 4'd0},   // R2
    '{16'h0C87, 4'b0001, 16'h0001, 4'b0001, 2'd1, 2'd0, 4'd1},   // R7 R8
    '{16'h5800, 4'b0110, 16'h0FF0, 4'b0100, 2'd1, 2'd1, 4'd15}   // R4
  };

  logic          clk;
  logic          rst_n;
  logic [N-1:0]  req_vld;
  logic [4*N-1:0] req_lvl;
  logic [N-1:0]  req_xfer;
  logic          psw_we;
  logic [15:0]   psw_wdata;
  logic          ret_stb;
  logic [15:0]   pop_data;
  logic          push_rdy;
  logic          ack_vld;
  logic [IW-1:0] ack_idx;
  logic          ack_xfer;
  logic          push_vld;
  logic [15:0]   push_data;
  logic [15:0]   psw;
  logic          hold_en;

  int total = 0;
  int bad   = 0;

  irq_accept_ctrl #(.N_REQ(N)) dut (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_lvl(req_lvl),
    .req_xfer(req_xfer), .psw_we(psw_we), .psw_wdata(psw_wdata),
    .ret_stb(ret_stb), .pop_data(pop_data), .push_rdy(push_rdy),
    .ack_vld(ack_vld), .ack_idx(ack_idx), .ack_xfer(ack_xfer),
    .push_vld(push_vld), .push_data(push_data), .psw(psw), .hold_en(hold_en)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    req_vld = '0; req_lvl = '0; req_xfer = '0;
    psw_we = 1'b0; psw_wdata = '0; ret_stb = 1'b0; pop_data = '0;
    push_rdy = 1'b0;
  endtask

  task automatic sw_write(input logic [15:0] v);
    psw_we = 1'b1; psw_wdata = v;
    step();
    psw_we = 1'b0;
  endtask

  task automatic run_vec(input int n);
    vec_t v;
    logic [15:0] clean;
    v = VECS[n];
    clean = v.psw & 16'hFC7F;
    sw_write(v.psw);
    req_vld = v.vld; req_lvl = v.lvl; req_xfer = v.xf;
    @(negedge clk);
    chk($sformatf("R8 psw write v%0d", n), 32'(psw), 32'(clean));
    chk($sformatf("R8 hold_en v%0d", n), 32'(hold_en), 32'(clean[10]));
    chk($sformatf("R2 R3 ack in decision cycle v%0d", n), 32'(ack_vld), 32'(v.kind == 2'd2));
    if (v.kind == 2'd2) begin
      chk($sformatf("R6 xfer idx v%0d", n), 32'(ack_idx), 32'(v.idx));
      chk($sformatf("R6 xfer flag v%0d", n), 32'(ack_xfer), 32'd1);
    end
    step();
    idle_inputs();
    @(negedge clk);
    chk($sformatf("R5 R6 push offer v%0d", n), 32'(push_vld), 32'(v.kind == 2'd1));
    if (v.kind == 2'd1) begin
      chk($sformatf("R5 push data v%0d", n), 32'(push_data), 32'(clean));
      push_rdy = 1'b1;
      #1;
      chk($sformatf("R5 ack on push v%0d", n), 32'(ack_vld), 32'd1);
      chk($sformatf("R4 R7 ack idx v%0d", n), 32'(ack_idx), 32'(v.idx));
      chk($sformatf("R7 not xfer v%0d", n), 32'(ack_xfer), 32'd0);
      step();
      push_rdy = 1'b0;
      @(negedge clk);
      chk($sformatf("R5 level loaded v%0d", n), 32'(psw),
          32'({v.wl, clean[11:0]}));
      chk($sformatf("R5 push ends v%0d", n), 32'(push_vld), 32'd0);
    end else begin
      chk($sformatf("R6 psw kept v%0d", n), 32'(psw), 32'(clean));
    end
  endtask

  initial begin
    #(20000 * 10);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 psw in reset", 32'(psw), 32'h0);
    chk("R1 ack in reset", 32'(ack_vld), 32'd0);
    chk("R1 push in reset", 32'(push_vld), 32'd0);
    step();
    rst_n = 1'b1;
    repeat (3) step();
    @(negedge clk);
    chk("R1 psw after reset", 32'(psw), 32'h0);
    chk("R1 hold_en after reset", 32'(hold_en), 32'd0);

    for (int i = 0; i < NV; i++) begin
      run_vec(i);
    end

    // R8 R10: write and transfer grant in one cycle, old level judges
    sw_write(16'h0800);
    psw_we = 1'b1; psw_wdata = 16'hF800;
    req_vld = 4'b0001; req_lvl = 16'h000F; req_xfer = 4'b0001;
    @(negedge clk);
    chk("R10 grant with write", 32'(ack_vld), 32'd1);
    chk("R10 grant is xfer", 32'(ack_xfer), 32'd1);
    step();
    psw_we = 1'b0;
    @(negedge clk);
    chk("R8 new level refuses", 32'(ack_vld), 32'd0);
    chk("R8 new level stored", 32'(psw), 32'hF800);
    step();
    idle_inputs();

    // R10: write cycle starts no entry; strobes ignored while pushing
    sw_write(16'h0800);
    psw_we = 1'b1; psw_wdata = 16'h0800;
    req_vld = 4'b0100; req_lvl = 16'h0500; req_xfer = 4'b0000;
    @(negedge clk);
    chk("R10 no ack on write cycle", 32'(ack_vld), 32'd0);
    step();
    psw_we = 1'b0;
    @(negedge clk);
    chk("R10 no push after write cycle", 32'(push_vld), 32'd0);
    step();
    idle_inputs();
    @(negedge clk);
    chk("R10 entry starts late", 32'(push_vld), 32'd1);
    psw_we = 1'b1; psw_wdata = 16'h0000;
    ret_stb = 1'b1; pop_data = 16'hF000;
    step();
    idle_inputs();
    @(negedge clk);
    chk("R10 strobes ignored busy", 32'(psw), 32'h0800);
    chk("R5 push still offered", 32'(push_vld), 32'd1);
    push_rdy = 1'b1;
    #1;
    chk("R5 ack idx on late push", 32'(ack_idx), 32'd2);
    step();
    push_rdy = 1'b0;
    @(negedge clk);
    chk("R5 level after late push", 32'(psw), 32'h5800);

    // R9: return restores popped word, spare bits cleared
    ret_stb = 1'b1; pop_data = 16'h0980;
    step();
    ret_stb = 1'b0;
    @(negedge clk);
    chk("R9 return restores", 32'(psw), 32'h0800);

    // R10: write beats return in the same cycle
    psw_we = 1'b1; psw_wdata = 16'h2800;
    ret_stb = 1'b1; pop_data = 16'h7800;
    step();
    idle_inputs();
    @(negedge clk);
    chk("R10 write over return", 32'(psw), 32'h2800);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule